// File: doc/BRIEF.md
# Affine Stream Address Generator

This block sits beside a core's register file and turns reads and writes of stream registers into memory traffic. Each stream lane is programmed through a small register port with a base address, an iteration count and a stride for each of up to four nested loop levels, the number of levels in use, and a direction. Writing the control register starts the lane. From then on the lane walks the affine address pattern by itself and the core issues no load or store instructions.

A load lane sends read requests ahead of use and keeps the returned words in a small FIFO. The core takes one word per pop and stalls while the FIFO is empty. A store lane takes words from the core into its FIFO and sends them to memory in order, each with the next generated address. Two lanes run side by side, so a multiply-accumulate loop can be fed one operand pair per cycle. Each lane has its own memory port, and responses return in request order.

Top module: `stream_agu`

## Requirements
- R1: After reset every lane is idle: `busy_o`, `done_o`, `mreq_valid_o`, `pop_valid_o` and `push_ready_o` are all 0.
- R2: A configuration write goes to the lane named by `cfg_sel_i`. Register 0 holds the base address. Registers 1 to 4 hold the iteration count minus one for levels 0 to 3. Registers 5 to 8 hold the byte stride for levels 0 to 3. Register 9 is the control register: bits [1:0] give the number of levels minus one, bit 2 selects a store (1) or a load (0), and writing it raises `busy_o` in the next cycle.
- R3: Level 0 is the innermost level. Element k goes to the address base + sum of index_l * stride_l over the active levels, modulo 2^AW, and the indices advance in mixed-radix order.
- R4: A load lane never has more than DEPTH elements requested and not yet popped. If the consumer is stalled and memory is always ready, exactly DEPTH requests are accepted and `mreq_valid_o` then stays low.
- R5: A load lane delivers response data in element order. `pop_valid_o` is low while its FIFO is empty, and a pop while `pop_valid_o` is low is ignored.
- R6: A store lane sends the pushed words to memory in push order, with `mreq_we_o` high and the generated addresses. After it has accepted as many words as the pattern has elements, `push_ready_o` stays low.
- R7: After the final element, `done_o` rises and `busy_o` falls. For a load lane the final element is the last pop; for a store lane it is the last accepted memory write. `done_o` is cleared by the next launch.
- R8: Configuration writes to a busy lane, including writes to the control register, are ignored.
- R9: The two lanes run independently and at the same time. One lane can be configured and launched while the other is busy.
- R10: While `mreq_valid_o` is high and `mreq_ready_i` is low, the request stays valid and its address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | SW | Lane addressed by the write |
| cfg_reg_i | input | RW | Register index |
| cfg_wdata_i | input | AW | Write data |
| busy_o | output | NS | Lane running |
| done_o | output | NS | Lane finished its pattern |
| pop_i | input | NS | Core reads a stream register |
| pop_data_o | output | NS*DW | Head of the load FIFO |
| pop_valid_o | output | NS | Load data available; the core stalls while low |
| push_i | input | NS | Core writes a stream register |
| push_data_i | input | NS*DW | Data written by the core |
| push_ready_o | output | NS | Store lane accepts data |
| mreq_valid_o | output | NS | Memory request valid |
| mreq_ready_i | input | NS | Memory accepts the request |
| mreq_addr_o | output | NS*AW | Request address |
| mreq_we_o | output | NS | Request is a write |
| mreq_wdata_o | output | NS*DW | Write data |
| mrsp_valid_i | input | NS | Read response valid, in request order |
| mrsp_data_i | input | NS*DW | Read response data |

## Verification
The case that is hardest to reach from the ports is a load lane whose budget of requests is fully used up: the FIFO is partly filled and some responses are still in flight. To reach it, the bench holds the consumer off while memory answers every request with a four-cycle latency, then counts the accepted requests and watches the request line stay low. While the lane is still full, it tries to reconfigure that lane and checks afterwards that the drained data still follows the first pattern. A store lane is held against a stalled memory with a pattern shorter than the FIFO, which shows that the push side closes after the element count.

// File: rtl/stream_agu_pkg.sv
package stream_agu_pkg;
  typedef enum logic {
    DIR_LOAD  = 1'b0,
    DIR_STORE = 1'b1
  } dir_e;

  localparam int unsigned REG_BASE = 0;
  localparam int unsigned REG_BOUND_FIRST = 1;

  function automatic int unsigned reg_stride_first(int unsigned nl);
    return REG_BOUND_FIRST + nl;
  endfunction

  function automatic int unsigned reg_ctrl(int unsigned nl);
    return REG_BOUND_FIRST + 2 * nl;
  endfunction
endpackage

// File: rtl/stream_agu_fifo.sv
module stream_agu_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clear_i,
  input  logic                             push_i,
  input  logic [DW-1:0]                    data_i,
  input  logic                             pop_i,
  output logic [DW-1:0]                    data_o,
  output logic [$clog2(DEPTH+1)-1:0]       count_o,
  output logic                             full_o,
  output logic                             empty_o
);
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH+1);

  logic [DW-1:0]   mem_q [DEPTH];
  logic [PW-1:0]   wp_q, rp_q;
  logic [CNTW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= bump(wp_q);
      if (pop_i)  rp_q <= bump(rp_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CNTW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CNTW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= data_i;
  end

  assign data_o  = mem_q[rp_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNTW'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/stream_agu_iter.sv
module stream_agu_iter #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 8,
  parameter int unsigned NL = 4,
  parameter int unsigned LW = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   step_i,
  input  logic [AW-1:0]          base_i,
  input  logic [NL-1:0][CW-1:0]  bound_i,
  input  logic [NL-1:0][AW-1:0]  stride_i,
  input  logic [LW-1:0]          lev_i,
  output logic [AW-1:0]          addr_o,
  output logic                   last_o
);
  // per-level offset kept as a running sum, so no multipliers are needed
  logic [NL-1:0][CW-1:0] idx_q, idx_d;
  logic [NL-1:0][AW-1:0] off_q, off_d;

  always_comb begin
    logic carry;
    logic act;
    logic wrap;
    carry  = 1'b1;
    last_o = 1'b1;
    addr_o = base_i;
    for (int l = 0; l < NL; l++) begin
      act  = ((LW+1)'(l) <= {1'b0, lev_i});
      wrap = (idx_q[l] == bound_i[l]);
      if (act && !wrap) last_o = 1'b0;
      idx_d[l] = idx_q[l];
      off_d[l] = off_q[l];
      if (carry && act) begin
        if (wrap) begin
          idx_d[l] = '0;
          off_d[l] = '0;
        end else begin
          idx_d[l] = idx_q[l] + CW'(1);
          off_d[l] = off_q[l] + stride_i[l];
          carry    = 1'b0;
        end
      end
      addr_o = addr_o + off_q[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      off_q <= '0;
    end else if (start_i) begin
      idx_q <= '0;
      off_q <= '0;
    end else if (step_i) begin
      idx_q <= idx_d;
      off_q <= off_d;
    end
  end
endmodule

// File: rtl/stream_agu_lane.sv
module stream_agu_lane
  import stream_agu_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned CW    = 8,
  parameter int unsigned NL    = 4,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned RW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [RW-1:0] cfg_reg_i,
  input  logic [AW-1:0] cfg_wdata_i,
  output logic          busy_o,
  output logic          done_o,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_valid_o,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  output logic          push_ready_o,
  output logic          mreq_valid_o,
  input  logic          mreq_ready_i,
  output logic [AW-1:0] mreq_addr_o,
  output logic          mreq_we_o,
  output logic [DW-1:0] mreq_wdata_o,
  input  logic          mrsp_valid_i,
  input  logic [DW-1:0] mrsp_data_i
);
  localparam int unsigned LW   = (NL > 1) ? $clog2(NL) : 1;
  localparam int unsigned TW   = CW * NL;
  localparam int unsigned CNTW = $clog2(DEPTH+1);
  localparam int unsigned STR0 = reg_stride_first(NL);
  localparam int unsigned CTRL = reg_ctrl(NL);

  logic [AW-1:0]         base_q;
  logic [NL-1:0][CW-1:0] bound_q;
  logic [NL-1:0][AW-1:0] stride_q;
  logic [LW-1:0]         lev_q;
  dir_e                  dir_q;

  logic            busy_q, done_q, req_done_q, cons_done_q;
  logic [TW-1:0]   cons_left_q, total;
  logic [CNTW-1:0] outst_q, f_count;
  logic            f_full, f_empty, f_push, f_pop;
  logic [DW-1:0]   f_din, f_dout;
  logic            it_last;
  logic [AW-1:0]   it_addr;

  logic cfg_ok, launch, req_fire, pop_acc, push_acc, cons_evt, finish, store;

  assign cfg_ok = cfg_we_i && !busy_q;
  assign launch = cfg_ok && (cfg_reg_i == RW'(CTRL));
  assign store  = (dir_q == DIR_STORE);

  always_comb begin
    total = TW'(1);
    for (int l = 0; l < NL; l++) begin
      if ((LW+1)'(l) <= {1'b0, cfg_wdata_i[LW-1:0]})
        total = total * (TW'(bound_q[l]) + TW'(1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      bound_q  <= '0;
      stride_q <= '0;
      lev_q    <= '0;
      dir_q    <= DIR_LOAD;
    end else if (cfg_ok) begin
      if (cfg_reg_i == RW'(REG_BASE)) base_q <= cfg_wdata_i;
      for (int l = 0; l < NL; l++) begin
        if (cfg_reg_i == RW'(REG_BOUND_FIRST + l)) bound_q[l]  <= cfg_wdata_i[CW-1:0];
        if (cfg_reg_i == RW'(STR0 + l))            stride_q[l] <= cfg_wdata_i;
      end
      if (launch) begin
        lev_q <= cfg_wdata_i[LW-1:0];
        dir_q <= dir_e'(cfg_wdata_i[LW]);
      end
    end
  end

  stream_agu_iter #(.AW(AW), .CW(CW), .NL(NL), .LW(LW)) u_iter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (launch),
    .step_i   (req_fire),
    .base_i   (base_q),
    .bound_i  (bound_q),
    .stride_i (stride_q),
    .lev_i    (lev_q),
    .addr_o   (it_addr),
    .last_o   (it_last)
  );

  assign pop_valid_o  = busy_q && !store && !f_empty;
  assign push_ready_o = busy_q && store && !cons_done_q && !f_full;
  assign pop_acc      = pop_i && pop_valid_o;
  assign push_acc     = push_i && push_ready_o;

  // load lane: slot reserved by FIFO occupancy plus requests in flight
  always_comb begin
    mreq_valid_o = 1'b0;
    if (busy_q && !req_done_q) begin
      if (store) mreq_valid_o = !f_empty;
      else       mreq_valid_o = ({1'b0, f_count} + {1'b0, outst_q}) < (CNTW+1)'(DEPTH);
    end
  end

  assign req_fire     = mreq_valid_o && mreq_ready_i;
  assign mreq_addr_o  = it_addr;
  assign mreq_we_o    = busy_q && store;
  assign mreq_wdata_o = f_dout;

  assign f_push   = store ? push_acc : (busy_q && mrsp_valid_i);
  assign f_pop    = store ? req_fire : pop_acc;
  assign f_din    = store ? push_data_i : mrsp_data_i;
  assign cons_evt = store ? push_acc : pop_acc;
  assign finish   = store ? (req_fire && it_last) : (pop_acc && cons_left_q == '0);

  stream_agu_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (launch),
    .push_i  (f_push),
    .data_i  (f_din),
    .pop_i   (f_pop),
    .data_o  (f_dout),
    .count_o (f_count),
    .full_o  (f_full),
    .empty_o (f_empty)
  );

  assign pop_data_o = f_dout;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      req_done_q  <= 1'b0;
      cons_done_q <= 1'b0;
      cons_left_q <= '0;
      outst_q     <= '0;
    end else if (launch) begin
      busy_q      <= 1'b1;
      done_q      <= 1'b0;
      req_done_q  <= 1'b0;
      cons_done_q <= 1'b0;
      cons_left_q <= total - TW'(1);
      outst_q     <= '0;
    end else begin
      if (req_fire && it_last) req_done_q <= 1'b1;
      if (cons_evt) begin
        if (cons_left_q == '0) cons_done_q <= 1'b1;
        else                   cons_left_q <= cons_left_q - TW'(1);
      end
      if (!store) begin
        if (req_fire && !f_push)      outst_q <= outst_q + CNTW'(1);
        else if (f_push && !req_fire) outst_q <= outst_q - CNTW'(1);
      end
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/stream_agu.sv
module stream_agu #(
  parameter int unsigned NS    = 2,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned CW    = 8,
  parameter int unsigned NL    = 4,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned SW   = (NS > 1) ? $clog2(NS) : 1,
  localparam int unsigned RW   = $clog2(2*NL+2)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [SW-1:0]         cfg_sel_i,
  input  logic [RW-1:0]         cfg_reg_i,
  input  logic [AW-1:0]         cfg_wdata_i,
  output logic [NS-1:0]         busy_o,
  output logic [NS-1:0]         done_o,
  input  logic [NS-1:0]         pop_i,
  output logic [NS-1:0][DW-1:0] pop_data_o,
  output logic [NS-1:0]         pop_valid_o,
  input  logic [NS-1:0]         push_i,
  input  logic [NS-1:0][DW-1:0] push_data_i,
  output logic [NS-1:0]         push_ready_o,
  output logic [NS-1:0]         mreq_valid_o,
  input  logic [NS-1:0]         mreq_ready_i,
  output logic [NS-1:0][AW-1:0] mreq_addr_o,
  output logic [NS-1:0]         mreq_we_o,
  output logic [NS-1:0][DW-1:0] mreq_wdata_o,
  input  logic [NS-1:0]         mrsp_valid_i,
  input  logic [NS-1:0][DW-1:0] mrsp_data_i
);
  for (genvar s = 0; s < NS; s++) begin : g_lane
    stream_agu_lane #(
      .AW(AW), .DW(DW), .CW(CW), .NL(NL), .DEPTH(DEPTH), .RW(RW)
    ) u_lane (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cfg_we_i     (cfg_we_i && (cfg_sel_i == SW'(s))),
      .cfg_reg_i    (cfg_reg_i),
      .cfg_wdata_i  (cfg_wdata_i),
      .busy_o       (busy_o[s]),
      .done_o       (done_o[s]),
      .pop_i        (pop_i[s]),
      .pop_data_o   (pop_data_o[s]),
      .pop_valid_o  (pop_valid_o[s]),
      .push_i       (push_i[s]),
      .push_data_i  (push_data_i[s]),
      .push_ready_o (push_ready_o[s]),
      .mreq_valid_o (mreq_valid_o[s]),
      .mreq_ready_i (mreq_ready_i[s]),
      .mreq_addr_o  (mreq_addr_o[s]),
      .mreq_we_o    (mreq_we_o[s]),
      .mreq_wdata_o (mreq_wdata_o[s]),
      .mrsp_valid_i (mrsp_valid_i[s]),
      .mrsp_data_i  (mrsp_data_i[s])
    );
  end
endmodule

// File: rtl/stream_agu_chk.sv
module stream_agu_chk #(
  parameter int unsigned NS    = 2,
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NS-1:0]         busy_o,
  input logic [NS-1:0]         done_o,
  input logic [NS-1:0]         pop_i,
  input logic [NS-1:0]         pop_valid_o,
  input logic [NS-1:0]         push_ready_o,
  input logic [NS-1:0]         mreq_valid_o,
  input logic [NS-1:0]         mreq_ready_i,
  input logic [NS-1:0][AW-1:0] mreq_addr_o,
  input logic [NS-1:0]         mreq_we_o
);
  for (genvar s = 0; s < NS; s++) begin : g_chk
    logic [7:0] ahead_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ahead_q <= '0;
      else begin
        case ({mreq_valid_o[s] && mreq_ready_i[s] && !mreq_we_o[s], pop_i[s] && pop_valid_o[s]})
          2'b10:   ahead_q <= ahead_q + 8'd1;
          2'b01:   ahead_q <= ahead_q - 8'd1;
          default: ahead_q <= ahead_q;
        endcase
      end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o[s] |-> !mreq_valid_o[s] && !pop_valid_o[s] && !push_ready_o[s]);

    // R4
    run_ahead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ahead_q <= 8'(DEPTH));

    // R5
    dir_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pop_valid_o[s] && (push_ready_o[s] || mreq_we_o[s])));

    // R7
    done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[s] |-> !busy_o[s]);

    // R7
    done_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o[s]) |-> done_o[s]);

    // R10
    req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mreq_valid_o[s] && !mreq_ready_i[s] |=> mreq_valid_o[s] && $stable(mreq_addr_o[s]));
  end
endmodule

bind stream_agu stream_agu_chk #(.NS(NS), .AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pop_i        (pop_i),
  .pop_valid_o  (pop_valid_o),
  .push_ready_o (push_ready_o),
  .mreq_valid_o (mreq_valid_o),
  .mreq_ready_i (mreq_ready_i),
  .mreq_addr_o  (mreq_addr_o),
  .mreq_we_o    (mreq_we_o)
);

// File: tb/stream_agu_bench.sv
module stream_agu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2, AW = 32, DW = 32, DEPTH = 4;
  localparam int SW = 1, RW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [SW-1:0] cfg_sel_i = '0;
  logic [RW-1:0] cfg_reg_i = '0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic [NS-1:0] busy_o, done_o, pop_valid_o, push_ready_o, mreq_valid_o, mreq_we_o;
  logic [NS-1:0][DW-1:0] pop_data_o, mreq_wdata_o;
  logic [NS-1:0][AW-1:0] mreq_addr_o;
  logic [NS-1:0] pop_i = '0, push_i = '0, mreq_ready_i = '0, mrsp_valid_i = '0;
  logic [NS-1:0][DW-1:0] push_data_i = '0, mrsp_data_i = '0;

  stream_agu u_stream_agu (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int errs = 0, checks = 0, cyc = 0;
  logic [31:0] exp_addr [NS][64];
  int n_elem [NS];
  int pop_cnt [NS], push_cnt [NS], rcnt [NS], wcnt [NS];
  logic [NS-1:0] cons_en = '0, prod_en = '0, force_pop = '0, hold_mem = '0, rnd_mem = '0;
  logic [15:0] lfsr [NS];
  logic pv [NS][3];
  logic [31:0] pd [NS][3];

  function automatic logic [31:0] mem_val(logic [31:0] a);
    return a ^ 32'hC3A5_0F0F;
  endfunction

  function automatic logic [31:0] wval(int s, int k);
    return 32'hD000_0000 + 32'(s * 256 + k);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "watchdog", 32'(cyc), 0);
      summary();
    end
  end

  // consumer and producer act at the falling edge
  always @(negedge clk_i) begin
    for (int s = 0; s < NS; s++) begin
      if (cons_en[s] && pop_valid_o[s] && pop_cnt[s] < n_elem[s]) begin
        check(pop_data_o[s] == mem_val(exp_addr[s][pop_cnt[s]]), "R5 pop data",
              pop_data_o[s], mem_val(exp_addr[s][pop_cnt[s]]));
        pop_i[s] = 1'b1;
        pop_cnt[s]++;
      end else pop_i[s] = force_pop[s];
      if (prod_en[s] && push_ready_o[s]) begin
        push_i[s] = 1'b1;
        push_data_i[s] = wval(s, push_cnt[s]);
        push_cnt[s]++;
      end else push_i[s] = 1'b0;
    end
  end

  // memory model: in-order, fixed latency
  always @(posedge clk_i) begin
    for (int s = 0; s < NS; s++) begin
      logic hs;
      hs = mreq_valid_o[s] && mreq_ready_i[s];
      if (hs && mreq_we_o[s]) begin
        check(mreq_addr_o[s] == exp_addr[s][wcnt[s]], "R6 write addr", mreq_addr_o[s], exp_addr[s][wcnt[s]]);
        check(mreq_wdata_o[s] == wval(s, wcnt[s]), "R6 write data", mreq_wdata_o[s], wval(s, wcnt[s]));
        wcnt[s]++;
      end else if (hs) begin
        check(mreq_addr_o[s] == exp_addr[s][rcnt[s]], "R3 read addr", mreq_addr_o[s], exp_addr[s][rcnt[s]]);
        rcnt[s]++;
      end
      lfsr[s] <= {lfsr[s][14:0], lfsr[s][15] ^ lfsr[s][13] ^ lfsr[s][12] ^ lfsr[s][10]};
      mreq_ready_i[s] <= !hold_mem[s] && (!rnd_mem[s] || lfsr[s][0] || lfsr[s][3]);
      pv[s][0] <= hs && !mreq_we_o[s];
      pd[s][0] <= mem_val(mreq_addr_o[s]);
      pv[s][1] <= pv[s][0]; pd[s][1] <= pd[s][0];
      pv[s][2] <= pv[s][1]; pd[s][2] <= pd[s][1];
      mrsp_valid_i[s] <= pv[s][2];
      mrsp_data_i[s]  <= pd[s][2];
    end
  end

  task automatic cfg_write(int s, int r, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = SW'(s); cfg_reg_i = RW'(r); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // b: iteration counts per level, st: strides per level
  task automatic start(int s, logic [31:0] base, int lev, int b[4], logic [31:0] st[4], bit wr);
    pop_cnt[s] = 0; push_cnt[s] = 0; rcnt[s] = 0; wcnt[s] = 0;
    n_elem[s] = 1;
    for (int l = 0; l < lev; l++) n_elem[s] *= b[l];
    for (int k = 0; k < n_elem[s]; k++) begin
      int r;
      logic [31:0] a;
      r = k; a = base;
      for (int l = 0; l < lev; l++) begin
        a = a + 32'(r % b[l]) * st[l];
        r = r / b[l];
      end
      exp_addr[s][k] = a;
    end
    cfg_write(s, 0, base);
    for (int l = 0; l < 4; l++) begin
      cfg_write(s, 1 + l, 32'(b[l] - 1));
      cfg_write(s, 5 + l, st[l]);
    end
    cfg_write(s, 9, 32'(lev - 1) | (wr ? 32'd4 : 32'd0));
    check(busy_o[s] == 1'b1, "R2 busy after launch", 32'(busy_o[s]), 1);
    check(done_o[s] == 1'b0, "R7 done cleared on launch", 32'(done_o[s]), 0);
  endtask

  task automatic wait_idle(int s);
    int t;
    t = 0;
    while (busy_o[s] && t < 5000) begin
      @(negedge clk_i);
      t++;
    end
    check(!busy_o[s], "R7 lane finishes", 32'(busy_o[s]), 0);
    check(done_o[s], "R7 done raised", 32'(done_o[s]), 1);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      lfsr[s] = 16'hACE1 + 16'(s * 77);
      n_elem[s] = 0; pop_cnt[s] = 0; push_cnt[s] = 0; rcnt[s] = 0; wcnt[s] = 0;
      for (int j = 0; j < 3; j++) begin pv[s][j] = 1'b0; pd[s][j] = '0; end
    end
    repeat (3) @(negedge clk_i);
    check(busy_o == '0 && done_o == '0, "R1 idle flags", {busy_o, done_o}, 0);
    check(mreq_valid_o == '0 && pop_valid_o == '0 && push_ready_o == '0, "R1 idle handshakes",
          {mreq_valid_o, pop_valid_o, push_ready_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // two-level load, random memory
    cons_en[0] = 1'b1; rnd_mem = 2'b11;
    start(0, 32'h1000, 2, '{4, 3, 1, 1}, '{32'd4, 32'h40, 32'd0, 32'd0}, 0);
    wait_idle(0);
    check(pop_cnt[0] == 12, "R5 pops", 32'(pop_cnt[0]), 12);
    check(rcnt[0] == 12, "R3 requests", 32'(rcnt[0]), 12);

    // four-level load, stalled consumer, reconfiguration while busy
    cons_en[0] = 1'b0; rnd_mem = 2'b00;
    start(0, 32'h8000, 4, '{2, 2, 2, 2}, '{32'd8, -32'd4, 32'h100, -32'h20}, 0);
    force_pop[0] = 1'b1;
    repeat (2) @(negedge clk_i);
    force_pop[0] = 1'b0;
    repeat (40) @(negedge clk_i);
    check(rcnt[0] == DEPTH, "R4 requests capped", 32'(rcnt[0]), DEPTH);
    check(mreq_valid_o[0] == 1'b0, "R4 request idle when full", 32'(mreq_valid_o[0]), 0);
    check(pop_valid_o[0] == 1'b1, "R5 data ready", 32'(pop_valid_o[0]), 1);
    cfg_write(0, 0, 32'h000F_FFF0);
    cfg_write(0, 9, 32'd4);
    check(mreq_we_o[0] == 1'b0 && rcnt[0] == DEPTH, "R8 busy lane unchanged", 32'(rcnt[0]), DEPTH);
    // lane 1 can be started while lane 0 is busy
    prod_en[1] = 1'b1; rnd_mem = 2'b10;
    start(1, 32'h200, 3, '{3, 2, 2, 1}, '{32'd4, 32'h10, 32'h80, 32'd0}, 1);
    cons_en[0] = 1'b1;
    wait_idle(0);
    wait_idle(1);
    check(pop_cnt[0] == 16, "R8 original pattern drained", 32'(pop_cnt[0]), 16);
    check(wcnt[1] == 12, "R9 writes while other busy", 32'(wcnt[1]), 12);
    check(push_cnt[1] == 12, "R6 pushes", 32'(push_cnt[1]), 12);

    // store lane against stalled memory, pattern shorter than FIFO
    hold_mem[1] = 1'b1;
    start(1, 32'h3000, 1, '{2, 1, 1, 1}, '{32'd16, 32'd0, 32'd0, 32'd0}, 1);
    repeat (10) @(negedge clk_i);
    check(push_cnt[1] == 2, "R6 push count limited", 32'(push_cnt[1]), 2);
    check(push_ready_o[1] == 1'b0 && busy_o[1], "R6 push closed", 32'(push_ready_o[1]), 0);
    hold_mem[1] = 1'b0;
    wait_idle(1);
    check(wcnt[1] == 2, "R6 writes", 32'(wcnt[1]), 2);

    // both lanes together
    rnd_mem = 2'b11;
    start(0, 32'h4000, 1, '{20, 1, 1, 1}, '{32'd4, 32'd0, 32'd0, 32'd0}, 0);
    start(1, 32'h9000, 2, '{5, 3, 1, 1}, '{32'd8, 32'h100, 32'd0, 32'd0}, 1);
    wait_idle(0);
    wait_idle(1);
    check(pop_cnt[0] == 20, "R9 lane 0 pops", 32'(pop_cnt[0]), 20);
    check(wcnt[1] == 15, "R9 lane 1 writes", 32'(wcnt[1]), 15);

    // single element pattern
    start(0, 32'hFFFF_FFFC, 1, '{1, 1, 1, 1}, '{32'd4, 32'd0, 32'd0, 32'd0}, 0);
    wait_idle(0);
    check(pop_cnt[0] == 1 && rcnt[0] == 1, "R3 single element", 32'(pop_cnt[0]), 1);

    repeat (5) @(negedge clk_i);
    summary();
  end
endmodule